// File: doc/BRIEF.md
# SDRAM Row/Column Address Multiplexer

This block turns a word-aligned system byte address into the address signals an SDRAM array expects. These are a one-hot chip select for one of four external banks, a two-bit internal bank address and a thirteen-bit memory address. They are issued as a row phase, a column phase, or both. Each external bank has its own configuration: a column width code (8 to 11 column bits) and an internal bank count (2 or 4). Both choose how system address bits are placed on the pins. Every external bank also has an end boundary, expressed in units of address bits 27 and up from bit 22. The first bank whose boundary is above the address takes the access.

The block keeps one open-row record for every pairing of chip select and internal bank address. This lets it classify each request as a page hit or a page miss. A miss produces a row phase followed by a column phase. A hit produces only the column phase.

There are two ways to close rows. A pulse on a chip select's flush line marks all of that chip select's rows closed, as a precharge-all or refresh would. A request that asks for auto-precharge closes its own row after its column phase.

The controller is a three-state machine:
- IDLE: ready for a request.
- ROW: row phase on the pins.
- COL: column phase on the pins.

Its transitions are:
- IDLE to ROW on an accepted miss.
- IDLE to COL on an accepted hit.
- ROW to COL always.
- COL to IDLE always.
- IDLE to IDLE with no request.

Each phase lasts exactly one clock. Every request is a single transfer.

Top module: `sdram_addr_mux`

## Requirements
- R1: After reset, out_valid is 0 and req_ready is 1, out_cs is 0, and every open-row record is closed, so the first access to any location is a miss.
- R2: During a phase, out_cs is one-hot and selects the lowest external bank i with req_addr[27:22] < cfg_cs_end[6i+5:6i]. When no boundary is above the address, bank 3 is selected.
- R3: A miss gives, on the two clocks after acceptance, a row phase (out_valid=1, out_row=1) and then a column phase (out_row=0), with out_hit=0 in both. out_write repeats the request's write flag in every phase.
- R4: A hit gives one column phase on the clock after acceptance, with out_hit=1, and no row phase.
- R5: Row phase mapping, with c = 8 + code, where code is cfg_col_w[2i+1:2i] and h = 14 + c:
  - MA[c-1:0] = A[13+c:14].
  - MA[10:c] = A[13:c+3].
  - BA0 = A[10+code].
  - With 2 internal banks (cfg_four_bank[i]=0): MA11 = A[h], MA12 = A[h+1], BA1 = A[h+2].
  - With 4 internal banks: BA1 = A[h], MA11 = A[h+1], MA12 = A[h+2].
- R6: Column phase mapping:
  - MA[9:0] = A[11:2].
  - MA11 = A12 when code is 3, and 0 otherwise.
  - MA12 = 0.
  - BA equals the row-phase BA for the same request.
- R7: In the column phase, MA10 equals req_autopre. A request with req_autopre=1 closes its own row, so the next access to it is a miss.
- R8: A one-clock pulse on flush_cs[i] closes all rows of external bank i. Rows of other external banks are unaffected.
- R9: Open rows are tracked separately for each chip select and BA pair. A hit needs the same row on the same pair, and a different row on that pair is a miss.
- R10: req_ready is 1 only in IDLE. A request is accepted only when req_valid and req_ready are both 1. out_valid is 0 in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_col_w | input | 8 | Column width code per external bank, 2 bits each (0..3 = 8..11 columns) |
| cfg_four_bank | input | 4 | Per external bank: 1 = 4 internal banks, 0 = 2 |
| cfg_cs_end | input | 24 | Per external bank end boundary on address bits 27:22, 6 bits each |
| flush_cs | input | 4 | Per external bank pulse that closes all of its rows |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 28 | System byte address (bits 1:0 ignored) |
| req_write | input | 1 | Request is a write |
| req_autopre | input | 1 | Close the row after the column phase |
| out_valid | output | 1 | An address phase is on the pins |
| out_row | output | 1 | 1 = row phase, 0 = column phase |
| out_cs | output | 4 | One-hot chip select |
| out_ba | output | 2 | Internal bank address |
| out_ma | output | 13 | Memory address pins |
| out_hit | output | 1 | Current request is a page hit |
| out_write | output | 1 | Write flag of the current request |

## Verification
A corrupted open-row record appears at the ports on the very next request to that chip select and bank pair. That request either loses its row phase or gains one, and out_hit flips one clock after acceptance. A wrong mapping or a stale configuration shows up on out_ma or out_ba in that same first phase. A state machine that stalls or skips a state shows up as req_ready staying low, or as a row phase with no column phase after it. The sweep therefore drives every column width and bank count with walking-one and mixed addresses, and repeats each address, so that hits and misses are both compared each time.

// File: rtl/sdmux_pkg.sv
package sdmux_pkg;

    localparam int MA_W  = 13;
    localparam int BA_W  = 2;
    localparam int MAP_A = 28;

    typedef struct packed {
        logic [BA_W-1:0] ba;
        logic [MA_W-1:0] ma;
    } sd_addr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2
    } mux_state_t;

    function automatic sd_addr_t map_row(input logic [MAP_A-1:0] a,
                                         input logic [1:0] wcode,
                                         input logic four);
        sd_addr_t r;
        int c;
        int h;
        c = 8 + int'(wcode);
        h = 14 + c;
        r.ma = '0;
        for (int i = 0; i < 11; i++) begin
            r.ma[i] = (i < c) ? a[14+i] : a[i+3];
        end
        r.ma[11] = four ? a[h+1] : a[h];
        r.ma[12] = four ? a[h+2] : a[h+1];
        r.ba[1]  = four ? a[h]   : a[h+2];
        r.ba[0]  = a[10+int'(wcode)];
        return r;
    endfunction

    function automatic sd_addr_t map_col(input logic [MAP_A-1:0] a,
                                         input logic [1:0] wcode,
                                         input logic four,
                                         input logic pc);
        sd_addr_t r;
        sd_addr_t rw;
        rw = map_row(a, wcode, four);
        r.ba      = rw.ba;
        r.ma      = '0;
        r.ma[9:0] = a[11:2];
        r.ma[10]  = pc;
        r.ma[11]  = (wcode == 2'd3) ? a[12] : 1'b0;
        r.ma[12]  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sdmux_cs_decode.sv
module sdmux_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int END_W  = 6,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [END_W-1:0]        a_top,
    input  logic [NUM_CS*END_W-1:0] cfg_end,
    output logic [CS_W-1:0]         cs_idx
);

    always_comb begin
        cs_idx = CS_W'(NUM_CS - 1);
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (a_top < cfg_end[i*END_W +: END_W]) begin
                cs_idx = CS_W'(i);
            end
        end
    end

endmodule

// File: rtl/sdmux_map.sv
module sdmux_map
    import sdmux_pkg::*;
(
    input  logic [MAP_A-1:0] addr,
    input  logic [1:0]       wcode,
    input  logic             four,
    input  logic             pc,
    output sd_addr_t         row_a,
    output sd_addr_t         col_a
);

    always_comb begin
        row_a = map_row(addr, wcode, four);
        col_a = map_col(addr, wcode, four, pc);
    end

endmodule

// File: rtl/sdmux_rowtrack.sv
module sdmux_rowtrack #(
    parameter int NUM_CS = 4,
    parameter int NBA    = 4,
    parameter int ROW_W  = 13,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BAI_W = (NBA > 1) ? $clog2(NBA) : 1,
    localparam int NSLOT = NUM_CS * NBA,
    localparam int SLOT_W = CS_W + BAI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CS_W-1:0]   look_cs,
    input  logic [BAI_W-1:0]  look_ba,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_hit,
    input  logic              open_en,
    input  logic [CS_W-1:0]   open_cs,
    input  logic [BAI_W-1:0]  open_ba,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              close_en,
    input  logic [CS_W-1:0]   close_cs,
    input  logic [BAI_W-1:0]  close_ba,
    input  logic [NUM_CS-1:0] flush_cs
);

    logic [NSLOT-1:0] slot_v;
    logic [ROW_W-1:0] slot_row [NSLOT];
    logic [SLOT_W-1:0] look_slot, open_slot, close_slot;

    assign look_slot  = {look_cs, look_ba};
    assign open_slot  = {open_cs, open_ba};
    assign close_slot = {close_cs, close_ba};

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_v[s]   <= 1'b0;
                slot_row[s] <= '0;
            end else if (open_en && open_slot == SLOT_W'(s)) begin
                slot_v[s]   <= 1'b1;
                slot_row[s] <= open_row;
            end else if (flush_cs[s/NBA] || (close_en && close_slot == SLOT_W'(s))) begin
                slot_v[s]   <= 1'b0;
            end
        end

        assert_close_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (close_en && close_slot == SLOT_W'(s) && !(open_en && open_slot == SLOT_W'(s)))
            |=> !slot_v[s]);
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_cs[g] && !(open_en && open_cs == CS_W'(g)))
            |=> (slot_v[g*NBA +: NBA] == '0));
    end

    assign look_hit = slot_v[look_slot] && !flush_cs[look_cs] &&
                      (slot_row[look_slot] == look_row);

endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
    import sdmux_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    localparam int END_W = ADDR_W - 22,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int NBA   = 1 << BA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*NUM_CS-1:0]     cfg_col_w,
    input  logic [NUM_CS-1:0]       cfg_four_bank,
    input  logic [END_W*NUM_CS-1:0] cfg_cs_end,
    input  logic [NUM_CS-1:0]       flush_cs,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic                    req_autopre,
    output logic                    out_valid,
    output logic                    out_row,
    output logic [NUM_CS-1:0]       out_cs,
    output logic [BA_W-1:0]         out_ba,
    output logic [MA_W-1:0]         out_ma,
    output logic                    out_hit,
    output logic                    out_write
);

    mux_state_t state_q, state_d;

    logic [CS_W-1:0] dec_idx;
    logic [1:0]      sel_w;
    logic            sel_four;
    sd_addr_t        map_r, map_c;
    logic            look_hit;
    logic            accept;

    logic [CS_W-1:0] q_cs;
    sd_addr_t        q_row, q_col;
    logic            q_hit, q_write, q_ap;

    logic wire_unused;
    assign wire_unused = ^req_addr[1:0];

    sdmux_cs_decode #(.NUM_CS(NUM_CS), .END_W(END_W)) u_dec (
        .a_top   (req_addr[ADDR_W-1:22]),
        .cfg_end (cfg_cs_end),
        .cs_idx  (dec_idx)
    );

    assign sel_w    = cfg_col_w[dec_idx*2 +: 2];
    assign sel_four = cfg_four_bank[dec_idx];

    sdmux_map u_map (
        .addr  (req_addr[MAP_A-1:0]),
        .wcode (sel_w),
        .four  (sel_four),
        .pc    (req_autopre),
        .row_a (map_r),
        .col_a (map_c)
    );

    sdmux_rowtrack #(.NUM_CS(NUM_CS), .NBA(NBA), .ROW_W(MA_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_cs  (dec_idx),
        .look_ba  (map_r.ba),
        .look_row (map_r.ma),
        .look_hit (look_hit),
        .open_en  (state_q == ST_ROW),
        .open_cs  (q_cs),
        .open_ba  (q_row.ba),
        .open_row (q_row.ma),
        .close_en (state_q == ST_COL && q_ap),
        .close_cs (q_cs),
        .close_ba (q_col.ba),
        .flush_cs (flush_cs)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = look_hit ? ST_COL : ST_ROW;
            ST_ROW:  state_d = ST_COL;
            ST_COL:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cs    <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_hit   <= 1'b0;
            q_write <= 1'b0;
            q_ap    <= 1'b0;
        end else if (accept) begin
            q_cs    <= dec_idx;
            q_row   <= map_r;
            q_col   <= map_c;
            q_hit   <= look_hit;
            q_write <= req_write;
            q_ap    <= req_autopre;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        out_valid = 1'b0;
        out_row   = 1'b0;
        out_cs    = '0;
        out_ba    = '0;
        out_ma    = '0;
        out_hit   = 1'b0;
        out_write = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ROW: begin
                out_valid = 1'b1;
                out_row   = 1'b1;
                out_cs    = NUM_CS'(1) << q_cs;
                out_ba    = q_row.ba;
                out_ma    = q_row.ma;
                out_hit   = q_hit;
                out_write = q_write;
            end
            ST_COL: begin
                out_valid = 1'b1;
                out_cs    = NUM_CS'(1) << q_cs;
                out_ba    = q_col.ba;
                out_ma    = q_col.ma;
                out_hit   = q_hit;
                out_write = q_write;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_cs) == 1));

    assert_row_then_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row) |=> (out_valid && !out_row && !out_hit));

    assert_hit_col_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> !out_row);

    assert_ba_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row) |=> (out_ba == $past(out_ba) && out_cs == $past(out_cs)));

    assert_col_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_row) |-> !out_ma[12]);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    assert_col_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_row) |=> req_ready);

endmodule

// File: tb/tb_sdram_addr_mux.sv
`timescale 1ns/1ps
module tb_sdram_addr_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_col_w = '0;
    logic [3:0]  cfg_four_bank = '0;
    logic [23:0] cfg_cs_end = '0;
    logic [3:0]  flush_cs = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_autopre = 1'b0;
    logic        out_valid, out_row, out_hit, out_write;
    logic [3:0]  out_cs;
    logic [1:0]  out_ba;
    logic [12:0] out_ma;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    bit          m_val [4][4];
    logic [12:0] m_row [4][4];

    always #2.5 clk = ~clk;

    sdram_addr_mux dut (
        .clk(clk), .rst_n(rst_n), .cfg_col_w(cfg_col_w), .cfg_four_bank(cfg_four_bank),
        .cfg_cs_end(cfg_cs_end), .flush_cs(flush_cs), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .req_autopre(req_autopre), .out_valid(out_valid), .out_row(out_row),
        .out_cs(out_cs), .out_ba(out_ba), .out_ma(out_ma), .out_hit(out_hit),
        .out_write(out_write)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_cs(input logic [27:0] a);
        int idx = 3;
        for (int i = 3; i >= 0; i--) begin
            if (int'(a[27:22]) < int'(cfg_cs_end[i*6 +: 6])) idx = i;
        end
        return idx;
    endfunction

    function automatic int exp_row(input int a, input int k, input bit f);
        int c = 8 + k;
        int h = 14 + c;
        int lo = (a >> 14) & ((1 << c) - 1);
        int mid = (a >> (c + 3)) & ((1 << (11 - c)) - 1);
        int b = (a >> h) & 7;
        int ma11, ma12, ba1, ba0;
        if (!f) begin
            ma11 = b & 1; ma12 = (b >> 1) & 1; ba1 = (b >> 2) & 1;
        end else begin
            ba1 = b & 1; ma11 = (b >> 1) & 1; ma12 = (b >> 2) & 1;
        end
        ba0 = (a >> (10 + k)) & 1;
        return (((ba1 << 1) | ba0) << 13) | lo | (mid << c) | (ma11 << 11) | (ma12 << 12);
    endfunction

    function automatic int exp_col(input int a, input int k, input bit pc);
        int ma = ((a >> 2) & 1023) | (int'(pc) << 10);
        if (k == 3) ma = ma | (((a >> 12) & 1) << 11);
        return ma;
    endfunction

    task automatic model_clear(input int cs);
        for (int b = 0; b < 4; b++) m_val[cs][b] = 0;
    endtask

    task automatic flush(input logic [3:0] mask);
        @(negedge clk);
        flush_cs = mask;
        @(negedge clk);
        flush_cs = '0;
        for (int i = 0; i < 4; i++) if (mask[i]) model_clear(i);
    endtask

    task automatic run_req(input logic [27:0] a, input bit wr, input bit ap);
        int cs, k, r, ba, rma, cma;
        bit f, hit;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready in idle", req_ready, 1);
        cs  = exp_cs(a);
        k   = int'(cfg_col_w[cs*2 +: 2]);
        f   = cfg_four_bank[cs];
        r   = exp_row(int'(a), k, f);
        ba  = (r >> 13) & 3;
        rma = r & 8191;
        cma = exp_col(int'(a), k, ap);
        hit = m_val[cs][ba] && (int'(m_row[cs][ba]) == rma);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_autopre = ap;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready low in phase", req_ready, 0);
        chk(out_cs == (4'b1 << cs), "R2", "chip select", out_cs, 1 << cs);
        chk(out_write == wr, "R3", "write flag", out_write, wr);
        if (!hit) begin
            chk(out_valid && out_row && !out_hit, "R3", "row phase flags",
                {out_valid, out_row, out_hit}, 3'b110);
            chk(out_ma == rma[12:0], "R5", "row MA", out_ma, rma);
            chk(out_ba == ba[1:0], "R5", "row BA", out_ba, ba);
            @(negedge clk);
            chk(out_valid && !out_row && !out_hit, "R3", "col after row",
                {out_valid, out_row, out_hit}, 3'b100);
        end else begin
            chk(out_valid && !out_row && out_hit, "R4", "hit column only",
                {out_valid, out_row, out_hit}, 3'b101);
        end
        chk(out_ma == cma[12:0], "R6", "col MA", out_ma, cma);
        chk(out_ba == ba[1:0], "R6", "col BA", out_ba, ba);
        chk(out_ma[10] == ap, "R7", "PC bit", out_ma[10], ap);
        m_val[cs][ba] = !ap;
        m_row[cs][ba] = rma[12:0];
        @(negedge clk);
        chk(!out_valid && req_ready, "R10", "back to idle", {out_valid, req_ready}, 2'b01);
    endtask

    task automatic expect_hit(input logic [27:0] a, input bit exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = 1'b0; req_autopre = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_hit == exp && out_row == !exp, req, "hit class", out_hit, exp);
        if (!exp) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [27:0] lfsr;
        logic [27:0] a;
        for (int i = 0; i < 4; i++) model_clear(i);
        cfg_cs_end = {6'd63, 6'd63, 6'd63, 6'd63};
        #12;
        chk(!out_valid && req_ready && out_cs == 0, "R1", "reset outputs",
            {out_valid, req_ready, out_cs}, 6'b010000);
        @(negedge clk);
        rst_n = 1'b1;
        run_req(28'h0000040, 1'b0, 1'b0);
        lfsr = 28'h5A3C1E7;
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 2; f++) begin
                cfg_col_w = {4{k[1:0]}};
                cfg_four_bank = {4{f[0]}};
                flush(4'hF);
                for (int b = 2; b < 28; b++) begin
                    a = 28'h1 << b;
                    run_req(a, b[0], 1'b0);
                    run_req(a, 1'b1, 1'b0);
                end
                for (int n = 0; n < 16; n++) begin
                    lfsr = {lfsr[26:0], lfsr[27] ^ lfsr[24]};
                    a = lfsr & 28'hFFFFFFC;
                    if (a[27:22] == 6'h3F) a[22] = 1'b0;
                    run_req(a, n[0], 1'b0);
                    run_req(a, 1'b0, n[1]);
                end
            end
        end
        // R2 boundaries
        cfg_col_w = '0; cfg_four_bank = '0;
        cfg_cs_end = {6'd20, 6'd12, 6'd8, 6'd4};
        flush(4'hF);
        run_req({6'd0, 22'h12344}, 1'b0, 1'b0);
        run_req({6'd5, 22'h12344}, 1'b0, 1'b0);
        run_req({6'd9, 22'h12344}, 1'b0, 1'b0);
        run_req({6'd13, 22'h12344}, 1'b0, 1'b0);
        run_req({6'd40, 22'h12344}, 1'b0, 1'b0);
        // R7: auto-precharge closes the row
        run_req({6'd5, 22'h00100}, 1'b0, 1'b1);
        expect_hit({6'd5, 22'h00100}, 1'b0, "R7");
        expect_hit({6'd5, 22'h00100}, 1'b1, "R7");
        // R8: flush one chip select only
        expect_hit({6'd9, 22'h12344}, 1'b1, "R8");
        flush(4'b0010);
        expect_hit({6'd5, 22'h00100}, 1'b0, "R8");
        expect_hit({6'd9, 22'h12344}, 1'b1, "R8");
        // R9: pairs independent; a new row on a pair misses
        expect_hit({6'd0, 22'h00400}, 1'b0, "R9");
        expect_hit({6'd0, 22'h00000}, 1'b0, "R9");
        expect_hit({6'd0, 22'h00400}, 1'b1, "R9");
        expect_hit({6'd0, 22'h04400}, 1'b0, "R9");
        expect_hit({6'd0, 22'h00400}, 1'b0, "R9");
        // R10: holding valid during phases does not start a second request
        @(negedge clk);
        req_valid = 1'b1; req_addr = {6'd0, 22'h08000};
        @(negedge clk);
        chk(out_valid && out_row, "R10", "first accepted", {out_valid, out_row}, 2'b11);
        @(negedge clk);
        chk(out_valid && !out_row, "R10", "col despite valid", {out_valid, out_row}, 2'b10);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R10", "no second request", out_valid, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule